// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block produces the four coil-phase signals for a two-coil bipolar stepper motor. It keeps a position index on a ring of eight half-step positions, and every rising edge of the step clock moves the index by one position. The four phase outputs depend only on that index. Each output pair drives one coil through an external power stage.

Two level inputs set each move. The step-size select chooses between half steps, which visit every position on the ring, and full steps, which stay on the even positions and jump by two. The direction select chooses whether the index counts up or counts down. An active-high reset returns the index to the home position at once. While reset is held, the index stays at home and step clock edges have no effect.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst` is high, the position is 0 and the outputs (phA, phAn, phB, phBn) read 1010. This takes effect immediately and does not wait for a clock edge. Rising edges of `stepClk` that occur while `rst` is high leave the outputs at 1010.
- R2: With `halfSel` = 1 and `dirSel` = 0, each rising edge of `stepClk` raises the position index by one.
- R3: With `halfSel` = 1 and `dirSel` = 1, each rising edge of `stepClk` lowers the position index by one.
- R4: With `halfSel` = 0 and the index on an even position, each rising edge moves the index by two. The index goes up when `dirSel` = 0 and down when `dirSel` = 1, so only positions 0, 2, 4 and 6 are visited.
- R5: With `halfSel` = 0 and the index on an odd position, the next rising edge moves the index by one in the selected direction, onto the adjacent even position.
- R6: The outputs (phA, phAn, phB, phBn) decode the index as follows: 0→1010, 1→0010, 2→0110, 3→0100, 4→0101, 5→0001, 6→1001, 7→1000.
- R7: phA and phAn are never both 1. phB and phBn are never both 1.
- R8: The index wraps modulo 8. Counting up moves 7 to 0 (or 6 to 0 in full steps). Counting down moves 0 to 7 (or 0 to 6 in full steps).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stepClk | input | 1 | Step clock; the index moves on each rising edge |
| rst | input | 1 | Active-high reset; forces the home position and blocks steps |
| dirSel | input | 1 | 0 counts the index up, 1 counts it down |
| halfSel | input | 1 | 1 selects half steps, 0 selects full steps |
| phA | output | 1 | Coil A, positive phase |
| phAn | output | 1 | Coil A, negative phase |
| phB | output | 1 | Coil B, positive phase |
| phBn | output | 1 | Coil B, negative phase |

## Verification
A step request takes effect on the rising edge of `stepClk` where it is applied. The outputs decode the new index in the same half-period, because the decoder is combinational and follows a single register. The driver sets `dirSel` and `halfSel` while the clock is low, raises the clock, and queues the expected phase pattern. The monitor reads the outputs on the next falling edge, which is half a period after the register updates. Reset acts asynchronously, so it is checked one time unit after `rst` rises. Edges applied while reset is held queue the home pattern.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int POS_W   = 3;
  localparam int NUM_POS = 1 << POS_W;
  localparam int PHASE_W = 4;

  typedef logic [POS_W-1:0]   pos_t;
  typedef logic [PHASE_W-1:0] phase_t;

  // strobes from control to datapath for the coming edge
  typedef struct packed {
    logic moveDown;
    logic moveTwo;
  } step_ctrl_t;

  localparam pos_t   HOME_POS   = '0;
  localparam phase_t HOME_PHASE = 4'b1010;
endpackage

// File: rtl/stepper_ctrl.sv
module stepper_ctrl
  import stepper_pkg::*;
(
  input  logic       dirSel,
  input  logic       halfSel,
  input  pos_t       curPos,
  output step_ctrl_t strobe
);
  // full steps jump by two only from an even position; an odd one first realigns
  always_comb begin
    strobe.moveDown = dirSel;
    strobe.moveTwo  = !halfSel && !curPos[0];
  end
endmodule

// File: rtl/stepper_datapath.sv
module stepper_datapath
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  step_ctrl_t strobe,
  output pos_t       curPos,
  output phase_t     phase
);
  pos_t posQ;
  pos_t stepAmt;

  assign stepAmt = strobe.moveTwo ? pos_t'(2) : pos_t'(1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  posQ <= HOME_POS;
    else if (strobe.moveDown) posQ <= posQ - stepAmt;
    else                      posQ <= posQ + stepAmt;
  end

  assign curPos = posQ;

  // phase order: {A, A_n, B, B_n}
  always_comb begin
    phase[3] = (posQ == 3'd7) || (posQ == 3'd0) || (posQ == 3'd6);
    phase[2] = (posQ == 3'd2) || (posQ == 3'd3) || (posQ == 3'd4);
    phase[1] = (posQ == 3'd0) || (posQ == 3'd1) || (posQ == 3'd2);
    phase[0] = (posQ == 3'd4) || (posQ == 3'd5) || (posQ == 3'd6);
  end

  a_r7_coil_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phase[3] && phase[2]) && !(phase[1] && phase[0]));

  a_r1_home_held: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (phase == HOME_PHASE));

  a_r6_even_both_coils: assert property (@(posedge clk) disable iff (rst)
    !posQ[0] |-> ($countones(phase) == 2));
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_pkg::*;
(
  input  logic stepClk,
  input  logic rst,
  input  logic dirSel,
  input  logic halfSel,
  output logic phA,
  output logic phAn,
  output logic phB,
  output logic phBn
);
  step_ctrl_t strobe;
  pos_t       curPos;
  phase_t     phase;

  stepper_ctrl u_ctrl (
    .dirSel (dirSel),
    .halfSel(halfSel),
    .curPos (curPos),
    .strobe (strobe)
  );

  stepper_datapath u_dp (
    .clk   (stepClk),
    .rst   (rst),
    .strobe(strobe),
    .curPos(curPos),
    .phase (phase)
  );

  assign {phA, phAn, phB, phBn} = phase;

  a_r2_half_up: assert property (@(posedge stepClk) disable iff (rst)
    ($past(halfSel) && !$past(dirSel) && !$past(rst)) |-> (curPos == pos_t'($past(curPos) + 3'd1)));

  a_r3_half_down: assert property (@(posedge stepClk) disable iff (rst)
    ($past(halfSel) && $past(dirSel) && !$past(rst)) |-> (curPos == pos_t'($past(curPos) - 3'd1)));

  a_r4_full_stays_even: assert property (@(posedge stepClk) disable iff (rst)
    (!$past(halfSel) && !$past(rst)) |-> !curPos[0]);
endmodule

// File: tb/stepper_phase_seq_bench.sv
module stepper_phase_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] want;
    string      tag;
  } item_t;

  logic stepClk = 1'b0;
  logic rst     = 1'b1;
  logic dirSel  = 1'b0;
  logic halfSel = 1'b1;
  logic phA, phAn, phB, phBn;

  int checks = 0;
  int fails  = 0;
  int modelPos = 0;
  item_t expQ[$];
  bit done = 0;

  stepper_phase_seq u_stepper_phase_seq (
    .stepClk(stepClk), .rst(rst), .dirSel(dirSel), .halfSel(halfSel),
    .phA(phA), .phAn(phAn), .phB(phB), .phBn(phBn)
  );

  function automatic logic [3:0] phaseOf(int p);
    case (p & 7)
      0: return 4'b1010;  1: return 4'b0010;
      2: return 4'b0110;  3: return 4'b0100;
      4: return 4'b0101;  5: return 4'b0001;
      6: return 4'b1001;  default: return 4'b1000;
    endcase
  endfunction

  task automatic check(input logic [3:0] got, input logic [3:0] want, input string tag);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, want);
    end
  endtask

  // one step pulse; model the requirement and queue the expected pattern
  task automatic stepOnce(input logic dn, input logic half, input string tag);
    dirSel  = dn;
    halfSel = half;
    #(CLK_PERIOD/2);
    stepClk = 1'b1;
    if (rst) modelPos = 0;
    else if (half || (modelPos % 2 == 1)) modelPos = dn ? (modelPos + 7) % 8 : (modelPos + 1) % 8;
    else modelPos = dn ? (modelPos + 6) % 8 : (modelPos + 2) % 8;
    expQ.push_back('{phaseOf(modelPos), tag});
    #(CLK_PERIOD/2);
    stepClk = 1'b0;
  endtask

  // monitor: compare on the falling edge after each step
  always @(negedge stepClk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check({phA, phAn, phB, phBn}, it.want, it.tag);
      checks++;
      if ((phA && phAn) || (phB && phBn)) begin
        fails++;
        $display("FAIL R7: got %b expected no coil pair both high", {phA, phAn, phB, phBn});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    stepOnce(1'b0, 1'b1, "R1 edge during reset");
    #1;
    check({phA, phAn, phB, phBn}, 4'b1010, "R1 reset state");
    rst = 1'b0;
    modelPos = 0;
    for (int i = 0; i < 10; i++) stepOnce(1'b0, 1'b1, "R2 R6 R8 half up");
    for (int i = 0; i < 11; i++) stepOnce(1'b1, 1'b1, "R3 R6 R8 half down");
    for (int i = 0; i < 5; i++)  stepOnce(1'b0, 1'b0, "R4 R8 full up");
    stepOnce(1'b0, 1'b1, "R2 to odd");
    stepOnce(1'b0, 1'b0, "R5 odd realign up");
    for (int i = 0; i < 3; i++)  stepOnce(1'b0, 1'b0, "R4 full up after realign");
    stepOnce(1'b1, 1'b1, "R3 to odd");
    stepOnce(1'b1, 1'b0, "R5 odd realign down");
    for (int i = 0; i < 5; i++)  stepOnce(1'b1, 1'b0, "R4 R8 full down");
    stepOnce(1'b0, 1'b1, "R2 before reset");
    stepOnce(1'b0, 1'b1, "R2 before reset");
    #2;
    rst = 1'b1;
    #1;
    check({phA, phAn, phB, phBn}, 4'b1010, "R1 async home");
    for (int i = 0; i < 3; i++)  stepOnce(1'b0, 1'b1, "R1 edges ignored");
    rst = 1'b0;
    for (int i = 0; i < 3; i++)  stepOnce(1'b1, 1'b1, "R3 R8 after release");
    #(CLK_PERIOD * 2);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: got %0d pending items expected 0", expQ.size());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 5000);
        checks++; fails++;
        $display("FAIL R1: got watchdog expiry expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule